// File: doc/BRIEF.md
# Keyed Refresh Control Register with Refresh/Interval Timer

This block holds the refresh control word for a DRAM controller and runs an 8-bit counter that paces refresh. The control word can only be changed by a full 16-bit bus write whose upper byte equals the key 0x5A. Every other write is dropped, including byte-sized writes and word writes with a wrong key. The lower byte of an accepted write supplies the refresh-enable, refresh-mode and two-bit wait-state fields. The mode and wait-state fields are passed straight on to the DRAM sequencer.

The counter steps on each prescaled tick. When it equals the compare value it restarts from zero and produces an internal one-cycle match. With refresh enabled, the match moves a small request state machine from IDLE to PENDING. The machine stays in PENDING, with `refresh_req` high, until the sequencer acknowledges. With refresh disabled, the match appears on `timer_irq` instead, and the counter serves as an interval timer.

Only the power-on reset clears the control word. A warm (manual or standby) reset restarts the counter and the request machine but keeps the control word.

Top module: `rfsh_keyed_ctl`

## Requirements
- R1: While `por_n` is low, `rd_data` reads 0x0000, `cnt_val` is 0, and `refresh_req` and `timer_irq` are 0.
- R2: A write with `wr_en`=1, `wr_word`=1 and `wr_data[15:8]`=0x5A loads `wr_data[7:4]` into the control word. The new value is visible on `rd_data[7:4]` after that edge. `rd_data[15:8]` and `rd_data[3:0]` always read zero. Bit 7 is refresh enable, bit 6 is refresh mode and bits 5:4 are the wait-state count.
- R3: A write with `wr_word`=0, or with an upper byte other than 0x5A, leaves `rd_data` unchanged.
- R4: `warm_rst`=1 at a clock edge sets `cnt_val` to 0 and clears a pending request. It leaves `rd_data` unchanged.
- R5: `cnt_val` increments by one at each edge where `tick`=1 and `cnt_val`≠`cmp_val`. It holds at edges where `tick`=0.
- R6: At an edge where `tick`=1 and `cnt_val`=`cmp_val`, `cnt_val` becomes 0 and a match is registered.
- R7: With enable=0, a match raises `timer_irq` for exactly the one cycle after the matching edge. `refresh_req` stays 0.
- R8: With enable=1, a match drives the request machine from IDLE to PENDING at the next edge. `refresh_req` stays high until an edge with `refresh_ack`=1. `timer_irq` stays 0.
- R9: A match that arrives while PENDING is not queued. This includes a match whose cycle coincides with `refresh_ack`: after the ack the machine is IDLE and stays IDLE.
- R10: `rfsh_mode` equals control bit 6, and `rfsh_wait` equals control bits 5:4.
- R11: The match is routed according to the enable value held in the cycle after the matching edge. A keyed write at the matching edge therefore already decides the route.
- R12: If `cmp_val` is below `cnt_val`, the counter runs up to 255, wraps to 0 without a match, and then matches normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| warm_rst | input | 1 | Synchronous manual/standby reset; keeps the control word |
| wr_en | input | 1 | Bus write strobe |
| wr_word | input | 1 | 1 = full-word write, 0 = byte write |
| wr_data | input | 16 | Write data; key in 15:8, control in 7:4 |
| rd_data | output | 16 | Control word readback |
| tick | input | 1 | Prescaled count enable |
| cmp_val | input | 8 | Counter compare value |
| cnt_val | output | 8 | Current counter value |
| refresh_ack | input | 1 | Sequencer acknowledge of a refresh request |
| refresh_req | output | 1 | Pending refresh request (state PENDING) |
| timer_irq | output | 1 | One-cycle interval timer pulse |
| rfsh_mode | output | 1 | Refresh mode field |
| rfsh_wait | output | 2 | Refresh wait-state field |

## Verification
Two pairs of events can fall in the same cycle. The first is a registered match and an acknowledge. The bench lines up the fourth tick so that the match cycle carries `refresh_ack`. It then expects `refresh_req` low right after the ack and still low one cycle later, which shows the new match was dropped. The second pair is a keyed write that clears enable and the matching tick, both at the same edge. Here the bench expects a `timer_irq` pulse and no request, because the new enable governs the match cycle.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
    typedef enum logic [0:0] {
        RQ_IDLE = 1'b0,
        RQ_PEND = 1'b1
    } rq_state_e;

    typedef struct packed {
        logic       en;
        logic       mode;
        logic [1:0] wait_n;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/rfsh_key_reg.sv
module rfsh_key_reg
    import rfsh_pkg::*;
#(
    parameter int          WORD_W = 16,
    parameter logic [7:0]  KEY    = 8'h5A
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic              wr_word,
    input  logic [WORD_W-1:0] wr_data,
    output ctl_t              ctl_q
);
    localparam int HALF = WORD_W / 2;

    logic key_ok;
    assign key_ok = wr_en && wr_word && (wr_data[WORD_W-1:HALF] == KEY);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctl_q <= '0;
        end else if (key_ok) begin
            ctl_q <= wr_data[HALF-1:HALF-CTL_W];
        end
    end

    // R3
    key_guard_chk: assert property (@(posedge clk) disable iff (!por_n)
        !key_ok |=> $stable(ctl_q));

    // R2
    key_load_chk: assert property (@(posedge clk) disable iff (!por_n)
        key_ok |=> (ctl_q == $past(wr_data[HALF-1:HALF-CTL_W])));
endmodule

// File: rtl/rfsh_interval_cnt.sv
module rfsh_interval_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             warm_rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt,
    output logic             match
);
    logic hit;
    assign hit = tick && (cnt == cmp_val);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt   <= '0;
            match <= 1'b0;
        end else if (warm_rst) begin
            cnt   <= '0;
            match <= 1'b0;
        end else begin
            match <= hit;
            if (hit) begin
                cnt <= '0;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!por_n)
        (tick && (cnt != cmp_val) && !warm_rst) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!tick && !warm_rst) |=> $stable(cnt));

    // R6
    match_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (tick && (cnt == cmp_val) && !warm_rst) |=> (match && (cnt == '0)));
endmodule

// File: rtl/rfsh_req_fsm.sv
module rfsh_req_fsm
    import rfsh_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic warm_rst,
    input  logic match,
    input  logic en,
    input  logic ack,
    output logic req,
    output logic irq
);
    rq_state_e st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            RQ_IDLE: if (match && en) st_nx = RQ_PEND;
            RQ_PEND: if (ack)         st_nx = RQ_IDLE;
            default:                  st_nx = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st <= RQ_IDLE;
        end else if (warm_rst) begin
            st <= RQ_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        req = 1'b0;
        irq = 1'b0;
        unique case (st)
            RQ_IDLE: irq = match && !en;
            RQ_PEND: begin
                req = 1'b1;
                irq = match && !en;
            end
            default: ;
        endcase
    end

    // R8
    req_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        ((st == RQ_IDLE) && match && en && !warm_rst) |=> (st == RQ_PEND));

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        ((st == RQ_PEND) && !ack && !warm_rst) |=> (st == RQ_PEND));

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        ((st == RQ_PEND) && ack) |=> (st == RQ_IDLE));
endmodule

// File: rtl/rfsh_keyed_ctl.sv
module rfsh_keyed_ctl
    import rfsh_pkg::*;
#(
    parameter int         WORD_W = 16,
    parameter int         CNT_W  = 8,
    parameter logic [7:0] KEY    = 8'h5A
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst,
    input  logic              wr_en,
    input  logic              wr_word,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              tick,
    input  logic [CNT_W-1:0]  cmp_val,
    output logic [CNT_W-1:0]  cnt_val,
    input  logic              refresh_ack,
    output logic              refresh_req,
    output logic              timer_irq,
    output logic              rfsh_mode,
    output logic [1:0]        rfsh_wait
);
    localparam int HALF = WORD_W / 2;
    localparam int LOW  = HALF - CTL_W;

    ctl_t ctl;
    logic match;
    logic unused_low;

    assign unused_low = ^wr_data[LOW-1:0];

    rfsh_key_reg #(.WORD_W(WORD_W), .KEY(KEY)) u_reg (
        .clk     (clk),
        .por_n   (por_n),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .wr_data (wr_data),
        .ctl_q   (ctl)
    );

    rfsh_interval_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .por_n    (por_n),
        .warm_rst (warm_rst),
        .tick     (tick),
        .cmp_val  (cmp_val),
        .cnt      (cnt_val),
        .match    (match)
    );

    rfsh_req_fsm u_fsm (
        .clk      (clk),
        .por_n    (por_n),
        .warm_rst (warm_rst),
        .match    (match),
        .en       (ctl.en),
        .ack      (refresh_ack),
        .req      (refresh_req),
        .irq      (timer_irq)
    );

    assign rd_data   = {{HALF{1'b0}}, ctl, {LOW{1'b0}}};
    assign rfsh_mode = ctl.mode;
    assign rfsh_wait = ctl.wait_n;

    // R7
    irq_req_excl_chk: assert property (@(posedge clk) disable iff (!por_n)
        timer_irq |=> !$rose(refresh_req));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rd_data[WORD_W-1:HALF] == '0) && (rd_data[LOW-1:0] == '0));
endmodule

// File: tb/sim_rfsh_keyed_ctl.sv
module sim_rfsh_keyed_ctl;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        warm_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_word = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        tick = 1'b0;
    logic [7:0]  cmp_val = 8'd3;
    logic [7:0]  cnt_val;
    logic        refresh_ack = 1'b0;
    logic        refresh_req;
    logic        timer_irq;
    logic        rfsh_mode;
    logic [1:0]  rfsh_wait;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rfsh_keyed_ctl u0 (
        .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .wr_en(wr_en),
        .wr_word(wr_word), .wr_data(wr_data), .rd_data(rd_data), .tick(tick),
        .cmp_val(cmp_val), .cnt_val(cnt_val), .refresh_ack(refresh_ack),
        .refresh_req(refresh_req), .timer_irq(timer_irq),
        .rfsh_mode(rfsh_mode), .rfsh_wait(rfsh_wait)
    );

    // {wr_word, wr_data, expected rd_data}
    localparam logic [32:0] WVEC [0:7] = '{
        {1'b1, 16'h5A80, 16'h0080},
        {1'b1, 16'h5AFF, 16'h00F0},
        {1'b1, 16'h3C00, 16'h00F0},
        {1'b0, 16'h5A00, 16'h00F0},
        {1'b1, 16'h5A30, 16'h0030},
        {1'b1, 16'h5B00, 16'h0030},
        {1'b1, 16'h5A40, 16'h0040},
        {1'b1, 16'h5A00, 16'h0000}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic keyed(input logic [15:0] d);
        wr_en = 1'b1; wr_word = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0; wr_word = 1'b0; wr_data = '0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        for (int i = 0; i < n; i++) step();
        tick = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int irq_seen;
        step(); step();
        // R1 reset state
        chk(rd_data == 16'h0, "R1 rd", rd_data, 0);
        chk(cnt_val == 8'h0, "R1 cnt", cnt_val, 0);
        chk(!refresh_req && !timer_irq, "R1 req/irq", {refresh_req, timer_irq}, 0);
        por_n = 1'b1;
        step();

        // R2 / R3 register write vectors
        for (int i = 0; i < 8; i++) begin
            wr_en = 1'b1; wr_word = WVEC[i][32]; wr_data = WVEC[i][31:16];
            step();
            wr_en = 1'b0; wr_word = 1'b0; wr_data = '0;
            chk(rd_data == WVEC[i][15:0],
                (WVEC[i][32] && WVEC[i][31:24] == 8'h5A) ? "R2 keyed write" : "R3 ignored write",
                rd_data, WVEC[i][15:0]);
        end

        // R10 field outputs
        keyed(16'h5A70);
        chk(rfsh_mode == 1'b1 && rfsh_wait == 2'd3, "R10 fields", {rfsh_mode, rfsh_wait}, 3'b111);

        // R5 / R6 / R7 interval timer (enable=0, cmp=3)
        cmp_val = 8'd3;
        ticks(3);
        chk(cnt_val == 8'd3, "R5 count", cnt_val, 3);
        step();
        chk(cnt_val == 8'd3, "R5 hold", cnt_val, 3);
        ticks(1);
        chk(cnt_val == 8'd0, "R6 restart", cnt_val, 0);
        chk(timer_irq == 1'b1 && !refresh_req, "R7 irq pulse", {timer_irq, refresh_req}, 2'b10);
        step();
        chk(timer_irq == 1'b0, "R7 irq one cycle", timer_irq, 0);

        // R8 refresh request (enable=1)
        keyed(16'h5AB0);
        ticks(4);
        chk(!timer_irq && !refresh_req, "R8 no irq at match", {timer_irq, refresh_req}, 0);
        step();
        chk(refresh_req == 1'b1, "R8 req set", refresh_req, 1);
        step();
        chk(refresh_req == 1'b1, "R8 req held", refresh_req, 1);

        // R9 second match while pending is not queued
        ticks(4);
        step();
        chk(refresh_req == 1'b1 && !timer_irq, "R9 pending kept", {refresh_req, timer_irq}, 2'b10);
        refresh_ack = 1'b1;
        step();
        refresh_ack = 1'b0;
        chk(refresh_req == 1'b0, "R8 ack clears", refresh_req, 0);
        step();
        chk(refresh_req == 1'b0, "R9 not queued", refresh_req, 0);

        // R9 ack in the same cycle as a new match
        ticks(4);
        step();
        chk(refresh_req == 1'b1, "R9 setup pending", refresh_req, 1);
        ticks(4);
        refresh_ack = 1'b1;
        step();
        refresh_ack = 1'b0;
        chk(refresh_req == 1'b0, "R9 ack+match", refresh_req, 0);
        step();
        chk(refresh_req == 1'b0, "R9 ack+match stays idle", refresh_req, 0);

        // R4 warm reset
        ticks(4);
        step();
        ticks(2);
        chk(refresh_req == 1'b1 && cnt_val == 8'd2, "R4 setup", {refresh_req, cnt_val}, 9'h102);
        warm_rst = 1'b1;
        step();
        warm_rst = 1'b0;
        chk(cnt_val == 8'd0, "R4 cnt cleared", cnt_val, 0);
        chk(refresh_req == 1'b0, "R4 req cleared", refresh_req, 0);
        chk(rd_data == 16'h00B0, "R4 reg kept", rd_data, 16'h00B0);

        // R11 keyed write at the matching edge decides the route
        ticks(3);
        tick = 1'b1; wr_en = 1'b1; wr_word = 1'b1; wr_data = 16'h5A00;
        step();
        tick = 1'b0; wr_en = 1'b0; wr_word = 1'b0; wr_data = '0;
        chk(timer_irq == 1'b1, "R11 irq on switch", timer_irq, 1);
        step();
        chk(refresh_req == 1'b0, "R11 no req", refresh_req, 0);

        // R12 wrap when compare is below count
        cmp_val = 8'd200;
        ticks(5);
        cmp_val = 8'd2;
        irq_seen = 0;
        tick = 1'b1;
        for (int i = 0; i < 251; i++) begin
            step();
            if (timer_irq) irq_seen++;
        end
        tick = 1'b0;
        chk(cnt_val == 8'd0 && irq_seen == 0, "R12 wrap no match", {irq_seen[7:0], cnt_val}, 0);
        ticks(3);
        chk(timer_irq == 1'b1 && cnt_val == 8'd0, "R12 match after wrap", {timer_irq, cnt_val}, 9'h100);

        // R1 power-on reset clears the control word
        keyed(16'h5AF0);
        por_n = 1'b0;
        #1;
        chk(rd_data == 16'h0 && cnt_val == 8'h0, "R1 por clears", rd_data, 0);
        step();
        por_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule